// File: doc/BRIEF.md
# Integer Computational Execute Unit

This block executes the 32-bit base-integer computational instructions in a single clock cycle: register-immediate arithmetic and logic, register-register arithmetic and logic, load-upper-immediate and add-upper-immediate-to-PC. It holds its own 32-entry general register file. On every cycle with the valid strobe high, the unit splits the instruction word into its fields and reads the source registers. It computes the result and writes the destination register on that clock edge.

A separate combinational read port lets an observer look at any register. An instruction word with an unsupported major opcode raises the illegal output during that cycle and leaves the register file untouched. Reset is asynchronous and active-low. Its release is expected to be synchronous to the clock.

Top module: `exec_unit`

## Requirements
- R1: The major opcode is instruction bits [6:0]. Codes 0x13 (register-immediate), 0x33 (register-register), 0x37 (upper immediate) and 0x17 (upper immediate plus PC) are legal. With `instr_valid` high, any other code drives `illegal` high in that cycle and writes no register. `illegal` is low whenever `instr_valid` is low.
- R2: Bits [14:12] select the operation, and code 0 adds. For register-register, bit 30 set turns the add into rs1 minus rs2. For register-immediate, the 12-bit immediate in bits [31:20] is sign-extended, and bit 30 does not affect code 0.
- R3: Code 1 shifts left logically. The shift amount is the low 5 bits of the immediate, or the low 5 bits of rs2 for the register form.
- R4: Code 5 shifts right. Bit 30 set fills with the sign bit, and bit 30 clear fills with zeros, in both the immediate and the register form.
- R5: Code 2 is a signed less-than and code 3 an unsigned less-than. Both write 1 or 0. The immediate form compares against the sign-extended immediate, and bit 30 does not affect either code.
- R6: Codes 4, 6 and 7 give bitwise XOR, OR and AND.
- R7: Opcode 0x37 writes bits [31:12] followed by twelve zeros. Opcode 0x17 writes that value plus `pc`, modulo 2^32.
- R8: Register 0 always reads zero, and writes to it are discarded.
- R9: Reset low clears every register to zero.
- R10: With `instr_valid` low, no register changes, whatever the instruction word holds.
- R11: `dbg_value` shows the register selected by `dbg_sel` without delay. A write is visible there from the cycle after its clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| instr_valid | input | 1 | Instruction word is to be executed this cycle |
| instr_word | input | 32 | Instruction word |
| pc | input | 32 | Address of the instruction word |
| dbg_sel | input | 5 | Register index for the observation port |
| dbg_value | output | 32 | Contents of the selected register |
| illegal | output | 1 | Valid instruction with an unsupported opcode |

## Verification
Some behaviour depends on operand values that only earlier instructions can set up, because the register file has no direct load path. Examples are sign-filling right shifts of negative numbers, signed against unsigned comparison of opposite-sign operands, and register shift counts with bits above bit 4 set. The stimulus table is therefore ordered as a program. Early entries build negative values, small shift counts and a count of 34 with immediate adds, and later entries consume them. Each entry is checked through the observation port. Bit 30 is also placed deliberately in fields where it must be ignored: a large negative add immediate, and a less-than in register form.

// File: rtl/exec_unit_pkg.sv
package exec_unit_pkg;

  localparam int XLEN  = 32;
  localparam int NREGS = 32;
  localparam int RAW   = $clog2(NREGS);

  localparam logic [6:0] OPC_IMM   = 7'h13;
  localparam logic [6:0] OPC_REG   = 7'h33;
  localparam logic [6:0] OPC_LUI   = 7'h37;
  localparam logic [6:0] OPC_AUIPC = 7'h17;

  typedef enum logic [3:0] {
    ALU_ADD, ALU_SUB, ALU_SLL, ALU_SLT, ALU_SLTU,
    ALU_XOR, ALU_SRL, ALU_SRA, ALU_OR, ALU_AND
  } alu_op_e;

  typedef enum logic [1:0] {
    SRCA_REG, SRCA_PC, SRCA_ZERO
  } srca_e;

  typedef enum logic {
    SRCB_REG, SRCB_IMM
  } srcb_e;

  typedef struct packed {
    logic            legal;
    alu_op_e         op;
    srca_e           a_sel;
    srcb_e           b_sel;
    logic [RAW-1:0]  rd;
    logic [RAW-1:0]  rs1;
    logic [RAW-1:0]  rs2;
    logic [XLEN-1:0] imm;
  } dec_t;

  function automatic alu_op_e sel_op(input logic [2:0] f3, input logic alt);
    case (f3)
      3'd0:    return alt ? ALU_SUB : ALU_ADD;
      3'd1:    return ALU_SLL;
      3'd2:    return ALU_SLT;
      3'd3:    return ALU_SLTU;
      3'd4:    return ALU_XOR;
      3'd5:    return alt ? ALU_SRA : ALU_SRL;
      3'd6:    return ALU_OR;
      default: return ALU_AND;
    endcase
  endfunction

endpackage

// File: rtl/exec_unit_decode.sv
module exec_unit_decode
  import exec_unit_pkg::*;
(
  input  logic [31:0] instr,
  output dec_t        dec
);

  logic [6:0]  opcode;
  logic [2:0]  f3;
  logic        alt_bit;
  logic [31:0] imm_i;
  logic [31:0] imm_u;

  assign opcode  = instr[6:0];
  assign f3      = instr[14:12];
  assign alt_bit = instr[30];
  assign imm_i   = {{20{instr[31]}}, instr[31:20]};
  assign imm_u   = {instr[31:12], 12'b0};

  always_comb begin
    dec       = '0;
    dec.op    = ALU_ADD;
    dec.a_sel = SRCA_REG;
    dec.b_sel = SRCB_REG;
    dec.rd    = instr[11:7];
    dec.rs1   = instr[19:15];
    dec.rs2   = instr[24:20];
    case (opcode)
      OPC_IMM: begin
        dec.legal = 1'b1;
        dec.b_sel = SRCB_IMM;
        dec.imm   = imm_i;
        dec.op    = sel_op(f3, (f3 == 3'd5) ? alt_bit : 1'b0);
      end
      OPC_REG: begin
        dec.legal = 1'b1;
        dec.b_sel = SRCB_REG;
        dec.op    = sel_op(f3, (f3 == 3'd0 || f3 == 3'd5) ? alt_bit : 1'b0);
      end
      OPC_LUI: begin
        dec.legal = 1'b1;
        dec.a_sel = SRCA_ZERO;
        dec.b_sel = SRCB_IMM;
        dec.imm   = imm_u;
      end
      OPC_AUIPC: begin
        dec.legal = 1'b1;
        dec.a_sel = SRCA_PC;
        dec.b_sel = SRCB_IMM;
        dec.imm   = imm_u;
      end
      default: dec.legal = 1'b0;
    endcase
  end

endmodule

// File: rtl/exec_unit_alu.sv
module exec_unit_alu
  import exec_unit_pkg::*;
#(
  parameter int W = XLEN,
  parameter int SHW = $clog2(W)
) (
  input  alu_op_e      op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] y
);

  logic [SHW-1:0] shamt;
  assign shamt = b[SHW-1:0];

  always_comb begin
    case (op)
      ALU_ADD:  y = a + b;
      ALU_SUB:  y = a - b;
      ALU_SLL:  y = a << shamt;
      ALU_SLT:  y = W'($signed(a) < $signed(b));
      ALU_SLTU: y = W'(a < b);
      ALU_XOR:  y = a ^ b;
      ALU_SRL:  y = a >> shamt;
      ALU_SRA:  y = W'($signed(a) >>> shamt);
      ALU_OR:   y = a | b;
      default:  y = a & b;
    endcase
  end

endmodule

// File: rtl/exec_unit_rf.sv
module exec_unit_rf #(
  parameter int N  = 32,
  parameter int W  = 32,
  parameter int AW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] ra_a,
  output logic [W-1:0]  rd_a,
  input  logic [AW-1:0] ra_b,
  output logic [W-1:0]  rd_b,
  input  logic [AW-1:0] ra_dbg,
  output logic [W-1:0]  rd_dbg
);

  logic [N-1:0][W-1:0] rows;

  for (genvar i = 0; i < N; i++) begin : g_row
    if (i == 0) begin : g_zero
      assign rows[i] = '0;
    end else begin : g_reg
      logic         row_en;
      logic [W-1:0] row_d;
      logic [W-1:0] row_q;

      always_comb begin
        row_en = we && (waddr == AW'(i));
        row_d  = wdata;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          row_q <= '0;
        end else if (row_en) begin
          row_q <= row_d;
        end
      end

      assign rows[i] = row_q;
    end
  end

  assign rd_a   = rows[ra_a];
  assign rd_b   = rows[ra_b];
  assign rd_dbg = rows[ra_dbg];

endmodule

// File: rtl/exec_unit.sv
module exec_unit
  import exec_unit_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        instr_valid,
  input  logic [31:0] instr_word,
  input  logic [31:0] pc,
  input  logic [4:0]  dbg_sel,
  output logic [31:0] dbg_value,
  output logic        illegal
);

  dec_t            dec;
  logic [XLEN-1:0] rs1_val;
  logic [XLEN-1:0] rs2_val;
  logic [XLEN-1:0] op_a;
  logic [XLEN-1:0] op_b;
  logic [XLEN-1:0] result;
  logic            rf_we;
  logic [RAW-1:0]  rf_waddr;
  logic [XLEN-1:0] rf_wdata;

  exec_unit_decode u_dec (
    .instr (instr_word),
    .dec   (dec)
  );

  always_comb begin
    case (dec.a_sel)
      SRCA_PC:   op_a = pc;
      SRCA_ZERO: op_a = '0;
      default:   op_a = rs1_val;
    endcase
    op_b = (dec.b_sel == SRCB_IMM) ? dec.imm : rs2_val;
  end

  exec_unit_alu #(.W(XLEN)) u_alu (
    .op (dec.op),
    .a  (op_a),
    .b  (op_b),
    .y  (result)
  );

  always_comb begin
    rf_we    = instr_valid && dec.legal;
    rf_waddr = dec.rd;
    rf_wdata = result;
    illegal  = instr_valid && !dec.legal;
  end

  exec_unit_rf #(.N(NREGS), .W(XLEN)) u_rf (
    .clk    (clk),
    .rst_n  (rst_n),
    .we     (rf_we),
    .waddr  (rf_waddr),
    .wdata  (rf_wdata),
    .ra_a   (dec.rs1),
    .rd_a   (rs1_val),
    .ra_b   (dec.rs2),
    .rd_b   (rs2_val),
    .ra_dbg (dbg_sel),
    .rd_dbg (dbg_value)
  );

endmodule

// File: rtl/exec_unit_chk.sv
module exec_unit_chk
  import exec_unit_pkg::*;
(
  input logic            clk,
  input logic            rst_n,
  input logic            instr_valid,
  input logic [31:0]     instr_word,
  input logic            illegal,
  input logic            wr_en,
  input logic [RAW-1:0]  wr_addr,
  input logic [XLEN-1:0] wr_data,
  input logic [RAW-1:0]  dbg_sel,
  input logic [XLEN-1:0] dbg_value
);

  logic [6:0] opc;
  logic [2:0] f3;
  logic       known;

  assign opc   = instr_word[6:0];
  assign f3    = instr_word[14:12];
  assign known = (opc == OPC_IMM) || (opc == OPC_REG) ||
                 (opc == OPC_LUI) || (opc == OPC_AUIPC);

  AST_ILLEGAL_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> instr_valid); // R1

  AST_ILLEGAL_BLOCKS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> !wr_en); // R1

  AST_KNOWN_OPCODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    (instr_valid && known) |-> (!illegal && wr_en)); // R1

  AST_WRITE_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> instr_valid); // R10

  AST_ZERO_REG_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (dbg_sel == '0) |-> (dbg_value == '0)); // R8

  AST_UPPER_IMM_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && opc == OPC_LUI) |-> (wr_data == {instr_word[31:12], 12'b0})); // R7

  AST_COMPARE_IS_BOOL: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (opc == OPC_IMM || opc == OPC_REG) && (f3 == 3'd2 || f3 == 3'd3))
      |-> (wr_data[XLEN-1:1] == '0)); // R5

  AST_WRITE_VISIBLE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr != '0 && dbg_sel == wr_addr)
      |=> (!$stable(dbg_sel) || dbg_value == $past(wr_data))); // R11

endmodule

bind exec_unit exec_unit_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .instr_valid (instr_valid),
  .instr_word  (instr_word),
  .illegal     (illegal),
  .wr_en       (rf_we),
  .wr_addr     (rf_waddr),
  .wr_data     (rf_wdata),
  .dbg_sel     (dbg_sel),
  .dbg_value   (dbg_value)
);

// File: tb/exec_unit_test.sv
`timescale 1ns/1ps
module exec_unit_test;

  logic        clk;
  logic        rst_n;
  logic        instr_valid;
  logic [31:0] instr_word;
  logic [31:0] pc;
  logic [4:0]  dbg_sel;
  logic [31:0] dbg_value;
  logic        illegal;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 0;

  exec_unit uut (
    .clk         (clk),
    .rst_n       (rst_n),
    .instr_valid (instr_valid),
    .instr_word  (instr_word),
    .pc          (pc),
    .dbg_sel     (dbg_sel),
    .dbg_value   (dbg_value),
    .illegal     (illegal)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic logic [31:0] enc_i(input logic [11:0] imm, input logic [4:0] rs1,
                                        input logic [2:0] f3, input logic [4:0] rd);
    return {imm, rs1, f3, rd, 7'h13};
  endfunction

  function automatic logic [31:0] enc_r(input logic alt, input logic [4:0] rs2,
                                        input logic [4:0] rs1, input logic [2:0] f3,
                                        input logic [4:0] rd);
    return {1'b0, alt, 5'b0, rs2, rs1, f3, rd, 7'h33};
  endfunction

  typedef struct packed {
    logic [31:0] ins;
    logic [31:0] pcv;
    logic [4:0]  reg_id;
    logic [31:0] expv;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 36;
  localparam vec_t VECS [NV] = '{
    '{32'h00500093, 32'd0, 5'd1, 32'd5, 4'd2},                         // R2 add imm
    '{32'hffe00093, 32'd0, 5'd1, 32'hFFFFFFFE, 4'd2},                  // R2 negative imm
    '{enc_i(12'hFFA, 5'd0, 3'd0, 5'd1), 32'd0, 5'd1, 32'hFFFFFFFA, 4'd2}, // R2 x1=-6
    '{enc_i(12'h402, 5'd1, 3'd5, 5'd2), 32'd0, 5'd2, 32'hFFFFFFFE, 4'd4}, // R4 sign fill imm
    '{enc_i(12'h002, 5'd1, 3'd5, 5'd2), 32'd0, 5'd2, 32'h3FFFFFFE, 4'd4}, // R4 zero fill imm
    '{enc_i(12'd2,   5'd0, 3'd0, 5'd3), 32'd0, 5'd3, 32'd2, 4'd2},        // R2 x3=2
    '{enc_r(1'b1, 5'd3, 5'd1, 3'd5, 5'd4), 32'd0, 5'd4, 32'hFFFFFFFE, 4'd4}, // R4 sign fill reg
    '{enc_r(1'b0, 5'd3, 5'd1, 3'd5, 5'd4), 32'd0, 5'd4, 32'h3FFFFFFE, 4'd4}, // R4 zero fill reg
    '{enc_i(12'd6,   5'd0, 3'd0, 5'd5), 32'd0, 5'd5, 32'd6, 4'd2},        // R2 x5=6
    '{enc_i(12'd2,   5'd5, 3'd1, 5'd6), 32'd0, 5'd6, 32'd24, 4'd3},       // R3 left imm
    '{enc_i(12'h022, 5'd0, 3'd0, 5'd7), 32'd0, 5'd7, 32'd34, 4'd2},       // R2 x7=34
    '{enc_r(1'b0, 5'd7, 5'd5, 3'd1, 5'd8), 32'd0, 5'd8, 32'd24, 4'd3},    // R3 count 34 -> 2
    '{enc_i(12'd1,   5'd0, 3'd0, 5'd9), 32'd0, 5'd9, 32'd1, 4'd2},        // R2 x9=1
    '{enc_i(12'd31,  5'd9, 3'd1, 5'd8), 32'd0, 5'd8, 32'h80000000, 4'd3}, // R3 max count
    '{enc_r(1'b0, 5'd3, 5'd5, 3'd0, 5'd10), 32'd0, 5'd10, 32'd8, 4'd2},   // R2 add reg
    '{enc_r(1'b1, 5'd5, 5'd3, 3'd0, 5'd10), 32'd0, 5'd10, 32'hFFFFFFFC, 4'd2}, // R2 sub
    '{enc_i(12'hC00, 5'd0, 3'd0, 5'd11), 32'd0, 5'd11, 32'hFFFFFC00, 4'd2}, // R2 bit30 ignored
    '{enc_r(1'b0, 5'd3, 5'd1, 3'd2, 5'd12), 32'd0, 5'd12, 32'd1, 4'd5},   // R5 signed -6<2
    '{enc_r(1'b0, 5'd3, 5'd1, 3'd3, 5'd12), 32'd0, 5'd12, 32'd0, 4'd5},   // R5 unsigned
    '{enc_r(1'b1, 5'd3, 5'd1, 3'd2, 5'd12), 32'd0, 5'd12, 32'd1, 4'd5},   // R5 bit30 ignored
    '{enc_i(12'hFFF, 5'd5, 3'd2, 5'd12), 32'd0, 5'd12, 32'd0, 4'd5},      // R5 6 < -1 signed
    '{enc_i(12'hFFF, 5'd5, 3'd3, 5'd12), 32'd0, 5'd12, 32'd1, 4'd5},      // R5 sext imm unsigned
    '{enc_i(12'hFFB, 5'd1, 3'd2, 5'd12), 32'd0, 5'd12, 32'd1, 4'd5},      // R5 -6 < -5
    '{enc_i(12'd12,  5'd5, 3'd4, 5'd13), 32'd0, 5'd13, 32'd10, 4'd6},     // R6 xor imm
    '{enc_i(12'd12,  5'd5, 3'd6, 5'd13), 32'd0, 5'd13, 32'd14, 4'd6},     // R6 or imm
    '{enc_i(12'd12,  5'd5, 3'd7, 5'd13), 32'd0, 5'd13, 32'd4, 4'd6},      // R6 and imm
    '{enc_r(1'b0, 5'd3, 5'd5, 3'd4, 5'd13), 32'd0, 5'd13, 32'd4, 4'd6},   // R6 xor reg
    '{enc_r(1'b0, 5'd3, 5'd5, 3'd6, 5'd13), 32'd0, 5'd13, 32'd6, 4'd6},   // R6 or reg
    '{enc_r(1'b0, 5'd3, 5'd5, 3'd7, 5'd13), 32'd0, 5'd13, 32'd2, 4'd6},   // R6 and reg
    '{32'h0007b0b7, 32'd0,  5'd1, 32'd503808, 4'd7},                      // R7 upper imm
    '{32'h0007b097, 32'd12, 5'd1, 32'd503820, 4'd7},                      // R7 plus pc
    '{enc_i(12'd7,   5'd0, 3'd0, 5'd15), 32'd0, 5'd15, 32'd7, 4'd2},      // R2 x15=7
    '{{20'h80000, 5'd15, 7'h17}, 32'h80000000, 5'd15, 32'd0, 4'd7},       // R7 wraps
    '{enc_i(12'd5,   5'd0, 3'd0, 5'd0), 32'd0, 5'd0, 32'd0, 4'd8},        // R8 x0 write lost
    '{enc_r(1'b0, 5'd0, 5'd5, 3'd0, 5'd14), 32'd0, 5'd14, 32'd6, 4'd8},   // R8 x0 reads zero
    '{enc_i(12'h7FF, 5'd0, 3'd0, 5'd31), 32'd0, 5'd31, 32'h7FF, 4'd11}    // R11 top index
  };

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
    end
  endtask

  task automatic run(input logic [31:0] ins, input logic [31:0] pcv,
                     input logic vld, output logic ill);
    @(negedge clk);
    instr_word  = ins;
    pc          = pcv;
    instr_valid = vld;
    #1 ill = illegal;
    @(negedge clk);
    instr_valid = 1'b0;
  endtask

  task automatic peek(input logic [4:0] idx, output logic [31:0] val);
    dbg_sel = idx;
    #1 val = dbg_value;
  endtask

  task automatic check_all_zero(input string req);
    logic [31:0] v;
    for (int k = 0; k < 32; k++) begin
      peek(5'(k), v);
      check(req, $sformatf("x%0d after reset", k), v, 32'd0);
    end
  endtask

  initial begin
    logic        ill;
    logic [31:0] v;
    rst_n       = 1'b0;
    instr_valid = 1'b0;
    instr_word  = 32'd0;
    pc          = 32'd0;
    dbg_sel     = 5'd0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R9: reset state
    check_all_zero("R9");

    for (int i = 0; i < NV; i++) begin
      run(VECS[i].ins, VECS[i].pcv, 1'b1, ill);
      check($sformatf("R%0d", VECS[i].req), $sformatf("vector %0d illegal", i),
            32'(ill), 32'd0);
      peek(VECS[i].reg_id, v);
      check($sformatf("R%0d", VECS[i].req), $sformatf("vector %0d x%0d", i, VECS[i].reg_id),
            v, VECS[i].expv);
    end

    // R1: unsupported opcode 0x03 aimed at x5 (holds 6)
    run({12'd99, 5'd0, 3'd0, 5'd5, 7'h03}, 32'd0, 1'b1, ill);
    check("R1", "illegal flag on opcode 0x03", 32'(ill), 32'd1);
    peek(5'd5, v);
    check("R1", "x5 untouched by illegal word", v, 32'd6);

    // R1: unsupported opcode without valid raises nothing
    run({12'd99, 5'd0, 3'd0, 5'd5, 7'h7F}, 32'd0, 1'b0, ill);
    check("R1", "illegal flag with valid low", 32'(ill), 32'd0);

    // R10: legal word with valid low writes nothing
    run(enc_i(12'd99, 5'd0, 3'd0, 5'd5), 32'd0, 1'b0, ill);
    peek(5'd5, v);
    check("R10", "x5 unchanged with valid low", v, 32'd6);

    // R11: observation port follows selection without a clock edge
    peek(5'd31, v);
    check("R11", "x31 readback", v, 32'h7FF);
    peek(5'd13, v);
    check("R11", "x13 readback", v, 32'd2);

    // R9: reset in the middle of operation
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    check_all_zero("R9");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

endmodule